// File: doc/BRIEF.md
# I2C Master Bus-Primitive Sequencer

This block is the pin-level engine of an I2C master that is driven one bus primitive at a time. The host raises a single request line, and the block carries out that one event on the SCL and SDA lines: a Start, a Repeated Start, a Stop, an eight-bit receive, an acknowledge slot, or a byte transmit with the slave's acknowledge captured. While the event runs, a busy bit for that command reads back high. The block clears the bit itself when the event ends and raises a one-cycle completion pulse at the same time. The host has to order the primitives itself, for example Start, transmit address, receive, acknowledge, Stop.

Both bus lines are open-drain. Each is modelled as a drive-low enable, and SDA is also modelled as a sampled input. SCL low and high phases, and every set-up and hold interval of the bus conditions, last a whole number of "phases". One phase is `divider` clock cycles long. Nothing outside the block may stretch the clock. Slave operation and arbitration are not handled.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both drive-low enables are 0 (lines released), `cmd_busy` is 0, `done_irq` is 0, `rx_full` is 0 and `tx_nack` is 0.
- R2: A Start request is accepted on the clock edge where it is sampled, and `cmd_busy[0]` goes high at that edge. SCL is then released with SDA driven low for one phase, and after that both lines are driven low for one phase. Bit 0 then clears.
- R3: A Repeated Start (`cmd_busy[1]`) runs four phases. Each phase is written here as (SCL drive-low, SDA drive-low): (1,0), (0,0), (0,1), (1,1).
- R4: A Stop (`cmd_busy[2]`) runs three phases: (1,1), (0,1), (0,0). Both lines are released when it ends.
- R5: A receive (`cmd_busy[3]`) runs eight low/high SCL phase pairs with SDA released. At each edge where SCL is released it samples `sda_in`, most significant bit first. At completion SCL is driven low, `rx_byte` holds the eight sampled bits and `rx_full` sets.
- R6: A one-cycle `rx_read` pulse clears `rx_full`.
- R7: An acknowledge (`cmd_busy[4]`) runs a low phase and then a high phase of SCL, and ends with SCL driven low. SDA is driven low for the whole sequence when `ack_data` is 0 (ACK), and released when it is 1 (NACK). `ack_data` is captured when the request is accepted.
- R8: A `tx_write` (`cmd_busy[5]`) sends `tx_byte` MSB first. Each bit occupies a low/high phase pair, and SDA is driven low for a 0 bit. A ninth pair follows with SDA released. At that ninth SCL release `tx_nack` captures `sda_in` (1 = NACK). SCL is driven low at the end.
- R9: Only one command runs at a time. A request seen while a command is running is dropped and is never acted on later. When several requests arrive together, the lowest `cmd_busy` index wins: start, repeated start, stop, receive, acknowledge, transmit.
- R10: A Start request is ignored while `bus_idle` is 0.
- R11: `done_irq` is high for exactly one cycle. That cycle is the first cycle in which the busy bit of the finished command reads 0, and it occurs for every command kind.
- R12: A phase lasts `divider` clock cycles. A `divider` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divider | input | DIV_W | Clock cycles per bus phase |
| bus_idle | input | 1 | Bus is free; gates Start requests |
| req_start | input | 1 | Start request pulse |
| req_rstart | input | 1 | Repeated Start request pulse |
| req_stop | input | 1 | Stop request pulse |
| req_rx | input | 1 | Receive-byte request pulse |
| req_ack | input | 1 | Acknowledge-slot request pulse |
| ack_data | input | 1 | Value for the acknowledge slot (1 = NACK) |
| tx_write | input | 1 | Transmit request pulse |
| tx_byte | input | 8 | Byte to transmit |
| rx_read | input | 1 | Read strobe for the received byte |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| cmd_busy | output | 6 | One-hot running command (self-clearing bits) |
| rx_byte | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| tx_nack | output | 1 | Acknowledge bit captured after a transmit |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default `DIV_W` of 8 and changes `divider` at run time to 3, 1 and 0. Three cycles per phase makes each phase boundary visible as a distinct cycle in the waveform comparison. One cycle per phase puts a step advance on every edge. Zero exercises the clamp. A behavioural slave drives `sda_in` so that received bit order, acknowledge capture, dropped requests during a receive, and simultaneous-request priority can all be checked against a per-cycle expected waveform.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the I2C master sequencer.
// Assumes a byte of DATA_W bits and at most 2*DATA_W+2 phases per command.
package i2c_seq_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_CMD = 6;
    localparam int STEP_W  = $clog2(2 * DATA_W + 2);

    typedef enum logic [2:0] {
        OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_RX, OP_ACK, OP_TX
    } op_t;

    // Index of the final phase of each command
    function automatic logic [STEP_W-1:0] last_step(op_t op);
        case (op)
            OP_START, OP_ACK: return STEP_W'(1);
            OP_STOP:          return STEP_W'(2);
            OP_RSTART:        return STEP_W'(3);
            OP_RX:            return STEP_W'(2 * DATA_W - 1);
            OP_TX:            return STEP_W'(2 * DATA_W + 1);
            default:          return '0;
        endcase
    endfunction
endpackage

// File: rtl/i2c_phase_timer.sv
// Phase timer: pulses tick on the last cycle of each bus phase.
// Assumes restart is asserted only while run is low; divider 0 acts as 1.
module i2c_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (divider == '0) ? '0 : divider - DIV_W'(1);
    assign tick = run && (cnt >= lim);

    // Count cycles inside the current phase
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || tick)  cnt <= '0;
        else if (run)              cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/i2c_drive_map.sv
// Maps (command, phase) to the two drive-low enables.
// Purely combinational; odd phases of receive, acknowledge and transmit release SCL.
module i2c_drive_map
    import i2c_seq_pkg::*;
(
    input  op_t               op,
    input  logic [STEP_W-1:0] step,
    input  logic              ack_lo,
    input  logic [DATA_W-1:0] tx,
    output logic              scl_lo,
    output logic              sda_lo
);
    logic [STEP_W-2:0] bitn;
    logic [DATA_W-1:0] tx_sh;

    assign bitn  = step[STEP_W-1:1];
    assign tx_sh = tx << bitn;

    // Select the line pattern of this phase
    always_comb begin
        scl_lo = 1'b0;
        sda_lo = 1'b0;
        case (op)
            OP_START: begin scl_lo = step[0]; sda_lo = 1'b1; end
            OP_RSTART: begin
                scl_lo = (step == STEP_W'(0)) || (step == STEP_W'(3));
                sda_lo = step[1];
            end
            OP_STOP: begin
                scl_lo = (step == STEP_W'(0));
                sda_lo = (step != STEP_W'(2));
            end
            OP_RX:  scl_lo = ~step[0];
            OP_ACK: begin scl_lo = ~step[0]; sda_lo = ack_lo; end
            OP_TX: begin
                scl_lo = ~step[0];
                sda_lo = (32'(bitn) < DATA_W) ? ~tx_sh[DATA_W-1] : 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_byte_shift.sv
// Serial-in shift register, MSB first, for the bits seen at each SCL release.
// Assumes sample is asserted once per bit.
module i2c_byte_shift
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sda_in,
    output logic [DATA_W-1:0] shreg
);
    // Shift the sampled line level in at the low end
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (sample) shreg <= {shreg[DATA_W-2:0], sda_in};
    end
endmodule

// File: rtl/i2c_cmd_master.sv
// I2C master primitive sequencer: runs one requested bus event at a time and
// clears its busy bit on completion. Assumes no other device stretches SCL.
module i2c_cmd_master
    import i2c_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   divider,
    input  logic               bus_idle,
    input  logic               req_start,
    input  logic               req_rstart,
    input  logic               req_stop,
    input  logic               req_rx,
    input  logic               req_ack,
    input  logic               ack_data,
    input  logic               tx_write,
    input  logic [DATA_W-1:0]  tx_byte,
    input  logic               rx_read,
    input  logic               sda_in,
    output logic               scl_drive_low,
    output logic               sda_drive_low,
    output logic [NUM_CMD-1:0] cmd_busy,
    output logic [DATA_W-1:0]  rx_byte,
    output logic               rx_full,
    output logic               tx_nack,
    output logic               done_irq
);
    op_t               op, op_n, sel;
    logic [STEP_W-1:0] step, step_n;
    logic              ack_q, ack_n;
    logic [DATA_W-1:0] tx_q, tx_n, shreg;
    logic              accept, tick, fin, sample, map_scl, map_sda;

    // Pick the winning request by fixed priority
    always_comb begin
        sel = OP_IDLE;
        if (req_start && bus_idle) sel = OP_START;
        else if (req_rstart)       sel = OP_RSTART;
        else if (req_stop)         sel = OP_STOP;
        else if (req_rx)           sel = OP_RX;
        else if (req_ack)          sel = OP_ACK;
        else if (tx_write)         sel = OP_TX;
    end

    assign accept = (op == OP_IDLE) && (sel != OP_IDLE);
    assign fin    = tick && (step == last_step(op));
    assign sample = tick && !step[0] && ((op == OP_RX) || (op == OP_TX));
    assign ack_n  = accept ? ack_data : ack_q;
    assign tx_n   = accept ? tx_byte  : tx_q;

    // Next command and phase
    always_comb begin
        op_n   = op;
        step_n = step;
        if (accept) begin
            op_n   = sel;
            step_n = '0;
        end else if (fin) begin
            op_n   = OP_IDLE;
            step_n = '0;
        end else if (tick) begin
            step_n = step + STEP_W'(1);
        end
    end

    i2c_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(accept),
        .run(op != OP_IDLE), .divider(divider), .tick(tick)
    );

    i2c_drive_map map_i (
        .op(op_n), .step(step_n), .ack_lo(~ack_n), .tx(tx_n),
        .scl_lo(map_scl), .sda_lo(map_sda)
    );

    i2c_byte_shift shift_i (
        .clk(clk), .rst_n(rst_n), .sample(sample), .sda_in(sda_in), .shreg(shreg)
    );

    // Command state and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op    <= OP_IDLE;
            step  <= '0;
            ack_q <= 1'b0;
            tx_q  <= '0;
        end else begin
            op    <= op_n;
            step  <= step_n;
            ack_q <= ack_n;
            tx_q  <= tx_n;
        end
    end

    // Line drivers: new pattern per phase, SCL parked low after data events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
        end else if (fin) begin
            scl_drive_low <= (op != OP_STOP);
        end else if (accept || tick) begin
            scl_drive_low <= map_scl;
            sda_drive_low <= map_sda;
        end
    end

    // Completion pulse, received byte, full flag and acknowledge status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_irq <= 1'b0;
            rx_byte  <= '0;
            rx_full  <= 1'b0;
            tx_nack  <= 1'b0;
        end else begin
            done_irq <= fin;
            if (fin && (op == OP_RX)) begin
                rx_byte <= shreg;
                rx_full <= 1'b1;
            end else if (rx_read) begin
                rx_full <= 1'b0;
            end
            if (sample && (op == OP_TX) && (step == STEP_W'(2 * DATA_W)))
                tx_nack <= sda_in;
        end
    end

    // One busy bit per command kind, in priority order
    for (genvar i = 0; i < NUM_CMD; i++) begin : g_busy
        assign cmd_busy[i] = (op == op_t'(3'(i + 1)));
    end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
// Protocol checker for i2c_cmd_master, bound to every instance.
// Observes ports only.
module i2c_cmd_master_chk #(
    parameter int NB = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_drive_low,
    input logic          sda_drive_low,
    input logic [NB-1:0] cmd_busy,
    input logic          rx_full,
    input logic          done_irq
);
    assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_busy));

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (cmd_busy == '0) && ($past(cmd_busy) != '0));

    assert_start_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy[0]) |-> (!scl_drive_low && sda_drive_low));

    assert_stop_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy[2]) |-> (!scl_drive_low && !sda_drive_low));

    assert_rx_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy[3]) |-> rx_full);

    assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy[5] && $past(cmd_busy[5]) && !$stable(sda_drive_low)) |-> scl_drive_low);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(.NB(i2c_seq_pkg::NUM_CMD)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .cmd_busy(cmd_busy),
    .rx_full(rx_full), .done_irq(done_irq)
);

// File: tb/i2c_cmd_master_tb_top.sv
// Bench: per-cycle expected waveform queue built from the requirements,
// plus a behavioural slave on SDA.
module i2c_cmd_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] divider = 8'd3;
    logic       bus_idle = 1'b1;
    logic [5:0] req = '0;
    logic       ack_data = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       rx_read = 1'b0;
    logic       sda_in;
    logic       scl_drive_low, sda_drive_low, rx_full, tx_nack, done_irq;
    logic [5:0] cmd_busy;
    logic [7:0] rx_byte;

    int         checks = 0;
    int         fails = 0;
    string      cur_req = "R1";
    logic [8:0] q[$];
    logic [8:0] hold = '0;
    int         k = 0;
    int         smode = 0;
    logic [7:0] pat = '0;
    logic       want_ack = 1'b0;
    logic       slave_rel;

    always #10 clk = ~clk;

    i2c_cmd_master dut_i (
        .clk(clk), .rst_n(rst_n), .divider(divider), .bus_idle(bus_idle),
        .req_start(req[0]), .req_rstart(req[1]), .req_stop(req[2]),
        .req_rx(req[3]), .req_ack(req[4]), .ack_data(ack_data),
        .tx_write(req[5]), .tx_byte(tx_byte), .rx_read(rx_read), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .cmd_busy(cmd_busy), .rx_byte(rx_byte), .rx_full(rx_full),
        .tx_nack(tx_nack), .done_irq(done_irq)
    );

    // Slave: presents receive data or an acknowledge, counts SCL releases
    always_comb begin
        slave_rel = 1'b1;
        if (smode == 1 && k < 8) slave_rel = pat[7-k];
        if (smode == 2 && k == 8) slave_rel = ~want_ack;
    end
    assign sda_in = ~sda_drive_low & slave_rel;
    always @(negedge scl_drive_low) k = k + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle against the expected waveform
    always @(posedge clk) begin
        logic [8:0] e, got;
        #2;
        if (rst_n) begin
            if (q.size() > 0) begin
                e = q.pop_front();
                hold = {6'b0, e[2:1], 1'b0};
            end else e = hold;
            got = {cmd_busy, scl_drive_low, sda_drive_low, done_irq};
            chk(got == e, cur_req, 32'(got), 32'(e));
        end
    end

    task automatic ph(input logic [5:0] b, input logic s, input logic d);
        int n = (divider == 0) ? 1 : int'(divider);
        repeat (n) q.push_back({b, s, d, 1'b0});
    endtask

    // Raise a set of request lines for one cycle; model the winner
    task automatic issue(input logic [5:0] mask);
        int w = -1;
        @(negedge clk);
        for (int i = 5; i >= 0; i--)
            if (mask[i] && !(i == 0 && !bus_idle)) w = i;
        if (q.size() != 0) w = -1;
        req = mask;
        case (w)
            0: begin ph(6'd1, 0, 1); ph(6'd1, 1, 1); q.push_back({6'd0, 2'b11, 1'b1}); end
            1: begin ph(6'd2, 1, 0); ph(6'd2, 0, 0); ph(6'd2, 0, 1); ph(6'd2, 1, 1);
                     q.push_back({6'd0, 2'b11, 1'b1}); end
            2: begin ph(6'd4, 1, 1); ph(6'd4, 0, 1); ph(6'd4, 0, 0);
                     q.push_back({6'd0, 2'b00, 1'b1}); end
            3: begin k = 0; smode = 1;
                     for (int b = 0; b < 8; b++) begin ph(6'd8, 1, 0); ph(6'd8, 0, 0); end
                     q.push_back({6'd0, 2'b10, 1'b1}); end
            4: begin ph(6'd16, 1, ~ack_data); ph(6'd16, 0, ~ack_data);
                     q.push_back({6'd0, 1'b1, ~ack_data, 1'b1}); end
            5: begin k = 0; smode = 2;
                     for (int b = 7; b >= 0; b--) begin
                         ph(6'd32, 1, ~tx_byte[b]); ph(6'd32, 0, ~tx_byte[b]);
                     end
                     ph(6'd32, 1, 0); ph(6'd32, 0, 0);
                     q.push_back({6'd0, 2'b10, 1'b1}); end
            default: ;
        endcase
        @(negedge clk);
        req = '0;
    endtask

    task automatic settle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        smode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk({scl_drive_low, sda_drive_low} == 2'b00, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
        chk(cmd_busy == 0 && !done_irq, "R1 busy/irq", {cmd_busy, done_irq}, 0);
        chk(!rx_full && !tx_nack, "R1 flags", {rx_full, tx_nack}, 0);

        cur_req = "R2";  issue(6'd1); settle();
        cur_req = "R8";  tx_byte = 8'hA5; want_ack = 1; issue(6'd32); settle();
        chk(tx_nack == 0, "R8 ack captured", tx_nack, 0);
        cur_req = "R3";  issue(6'd2); settle();
        cur_req = "R8";  tx_byte = 8'h3C; want_ack = 0; issue(6'd32); settle();
        chk(tx_nack == 1, "R8 nack captured", tx_nack, 1);

        cur_req = "R5";  pat = 8'hB2; issue(6'd8); settle();
        chk(rx_byte == 8'hB2, "R5 byte", rx_byte, 8'hB2);
        chk(rx_full == 1, "R5 full", rx_full, 1);
        cur_req = "R6";
        @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
        chk(rx_full == 0, "R6 cleared", rx_full, 0);

        cur_req = "R7";  ack_data = 0; issue(6'd16); settle();
        ack_data = 1; issue(6'd16); settle();

        cur_req = "R9";  pat = 8'h4D; issue(6'd8);
        repeat (10) @(negedge clk);
        issue(6'd4); issue(6'd1); settle();
        chk(rx_byte == 8'h4D, "R9 rx unaffected", rx_byte, 8'h4D);
        repeat (4) @(negedge clk);
        chk(cmd_busy == 0, "R9 dropped not latched", cmd_busy, 0);
        issue(6'b000110); settle();
        issue(6'b100100); settle();

        cur_req = "R10"; bus_idle = 0; issue(6'd1); repeat (4) @(negedge clk);
        chk(cmd_busy == 0, "R10 start ignored", cmd_busy, 0);
        bus_idle = 1;

        cur_req = "R12"; divider = 8'd1; issue(6'd1); settle(); issue(6'd4); settle();
        divider = 8'd0; issue(6'd1); settle();
        pat = 8'h81; issue(6'd8); settle();
        chk(rx_byte == 8'h81, "R12 rx at divider 0", rx_byte, 8'h81);
        issue(6'd4); settle();
        cur_req = "R11"; divider = 8'd2; issue(6'd1); settle(); issue(6'd4); settle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule